// File: doc/BRIEF.md
# Software Write-Lock Sequence Guard

This block sits between the write qualifier and the page sequencer of a paged parallel nonvolatile memory. Every qualified write event arrives as a one-cycle strobe with address and data. The guard watches that stream for two software commands. One is a three-write unlock prefix, which also turns the lock on. The other is a six-write sequence that turns the lock off. A lock flag survives the logic reset, which stands for a power cycle. Only a separate factory-clear input returns the flag to the unlocked state of a new device.

When the lock is off, ordinary writes flow on to the page sequencer. When it is on, a data write flows on only if the unlock prefix came just before it in the same load session. A load session is a run of writes in which no gap exceeds `LOAD_LIMIT` cycles. Command bytes are never forwarded. If a session ends without forwarding anything, the guard emits a dummy-program kick. That kick lets the programming timer run and report busy while no array data changes. A change of the lock flag waits for the programming-done pulse that follows the command.

Top module: `wp_guard`

## Requirements
- R1: After the factory clear, `protOn` is 0. While `rstN` is low, and in the cycle after its release, `passValid` and `dummyKick` are 0.
- R2: With the lock off, an ordinary write sampled at a clock edge appears on `passValid`/`passAddr`/`passData` for exactly the following cycle, with the same address and data.
- R3: The enable sequence is 0xAA to 0x05555, then 0x55 to 0x02AAA, then 0xA0 to 0x05555. None of these writes is forwarded. `protOn` does not change when the sequence completes. It goes to 1 in the cycle after the next `progDone` pulse, and it changes at no other time.
- R4: With the lock on, a write not preceded by the prefix is not forwarded. A session that forwards nothing raises `dummyKick` for one cycle, exactly `LOAD_LIMIT` cycles after its last write.
- R5: With the lock on, data writes that follow a complete prefix within the same session are forwarded.
- R6: The disable sequence writes 0xAA to 0x05555, 0x55 to 0x02AAA, 0x80 to 0x05555, 0xAA to 0x05555, 0x55 to 0x02AAA and 0x20 to 0x05555, in that order. None of these writes is forwarded. `protOn` goes to 0 after the next `progDone`, and ordinary writes are then forwarded again.
- R7: A gap of up to `LOAD_LIMIT` cycles between two write edges keeps the session open. A longer gap ends the session, and an unfinished sequence is dropped.
- R8: A write that does not match the next expected step of a partial sequence is handled as an ordinary write under the current lock state: forwarded if the lock is off, swallowed if it is on. The detector returns to idle, the bytes it held are dropped, and the lock is not changed.
- R9: Pulsing `rstN` does not change `protOn`.
- R10: Inside an unlocked session, a write to a command address with command data is ordinary data and is forwarded.
- R11: A session that forwarded at least one write never produces `dummyKick`, and `dummyKick` and `passValid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low logic reset (power cycle); does not touch the lock flag |
| factoryClrN | input | 1 | Active-low asynchronous clear of the lock flag (new-device state) |
| wrValid | input | 1 | One-cycle strobe of a qualified write event |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| progDone | input | 1 | Pulse from the programming timer when a programming period ends |
| passValid | output | 1 | Forwarded data write strobe to the page sequencer |
| passAddr | output | ADDR_W | Forwarded address |
| passData | output | 8 | Forwarded data |
| dummyKick | output | 1 | Starts a programming period that commits no data |
| protOn | output | 1 | Current lock flag |

## Verification
Ordinary writes are swept over many address and data values with the lock off, which shows that the forwarding path carries each value intact. Sequence breaks are tried at every partial position of both commands, with the lock on and with it off. These tell "handled as ordinary" apart from "held" and "dropped". The gap between prefix and data is swept from back-to-back up to two cycles past the limit, which pins the session boundary to the exact cycle. Lock changes are observed before and after the programming-done pulse and across a logic reset, which separates "pending" from "applied" and shows the flag persists.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_A     = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_B     = 8'h55;
  localparam logic [DATA_W-1:0] CODE_ON   = 8'hA0;
  localparam logic [DATA_W-1:0] CODE_ARM  = 8'h80;
  localparam logic [DATA_W-1:0] CODE_OFF  = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_E1, ST_E2, ST_D3, ST_D4, ST_D5, ST_OPEN
  } seqState_t;

  typedef struct packed {
    logic isKeyA;
    logic isKeyB;
    logic isEnable;
    logic isDisArm;
    logic isDisEnd;
  } cmdHit_t;

  typedef struct packed {
    logic pass;
    logic kick;
  } dpStrobe_t;
endpackage

// File: rtl/wp_guard_dp.sv
module wp_guard_dp
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LOAD_LIMIT = 37500,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 17'h05555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 17'h02AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dpStrobe_t         strb,
  output cmdHit_t           hit,
  output logic              gapFull,
  output logic              passValid,
  output logic [ADDR_W-1:0] passAddr,
  output logic [DATA_W-1:0] passData,
  output logic              dummyKick
);
  localparam int GAP_W = $clog2(LOAD_LIMIT + 1);
  localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(LOAD_LIMIT - 1);

  logic [GAP_W-1:0] gapCnt;
  logic atA, atB;

  assign atA = (wrAddr == CMD_ADDR_A);
  assign atB = (wrAddr == CMD_ADDR_B);

  always_comb begin
    hit.isKeyA   = atA && (wrData == KEY_A);
    hit.isKeyB   = atB && (wrData == KEY_B);
    hit.isEnable = atA && (wrData == CODE_ON);
    hit.isDisArm = atA && (wrData == CODE_ARM);
    hit.isDisEnd = atA && (wrData == CODE_OFF);
  end

  // cycles since the last write event, saturating at the limit
  always_ff @(posedge clk) begin
    if (!rstN)                gapCnt <= GAP_TOP;
    else if (wrValid)         gapCnt <= '0;
    else if (gapCnt != GAP_TOP) gapCnt <= gapCnt + 1'b1;
  end

  assign gapFull = (gapCnt == GAP_TOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passValid <= 1'b0;
      passAddr  <= '0;
      passData  <= '0;
      dummyKick <= 1'b0;
    end else begin
      passValid <= strb.pass;
      dummyKick <= strb.kick;
      if (strb.pass) begin
        passAddr <= wrAddr;
        passData <= wrData;
      end
    end
  end
endmodule

// File: rtl/wp_guard_ctrl.sv
module wp_guard_ctrl
  import wp_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      factoryClrN,
  input  logic      wrValid,
  input  cmdHit_t   hit,
  input  logic      gapFull,
  input  logic      progDone,
  output dpStrobe_t strb,
  output logic      protOn
);
  seqState_t state, nextState;
  logic sessActive, sessPassed;
  logic pendOn, pendOff;
  logic expire, passNow, setPend, clrPend;

  assign expire = sessActive && !wrValid && gapFull;

  always_comb begin
    nextState = state;
    passNow   = 1'b0;
    setPend   = 1'b0;
    clrPend   = 1'b0;
    if (wrValid) begin
      // default: ordinary write under the current lock, detector to idle
      nextState = ST_IDLE;
      passNow   = !protOn;
      unique case (state)
        ST_IDLE: if (hit.isKeyA) begin nextState = ST_E1; passNow = 1'b0; end
        ST_E1:   if (hit.isKeyB) begin nextState = ST_E2; passNow = 1'b0; end
        ST_E2: begin
          if (hit.isEnable) begin
            nextState = ST_OPEN; passNow = 1'b0; setPend = 1'b1;
          end else if (hit.isDisArm) begin
            nextState = ST_D3; passNow = 1'b0;
          end
        end
        ST_D3:   if (hit.isKeyA) begin nextState = ST_D4; passNow = 1'b0; end
        ST_D4:   if (hit.isKeyB) begin nextState = ST_D5; passNow = 1'b0; end
        ST_D5: begin
          if (hit.isDisEnd) begin
            nextState = ST_OPEN; passNow = 1'b0; clrPend = 1'b1;
          end
        end
        ST_OPEN: begin nextState = ST_OPEN; passNow = 1'b1; end
        default: nextState = ST_IDLE;
      endcase
    end else if (expire) begin
      nextState = ST_IDLE;
    end
  end

  always_comb begin
    strb.pass = passNow;
    strb.kick = expire && !sessPassed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sessActive <= 1'b0;
      sessPassed <= 1'b0;
      pendOn     <= 1'b0;
      pendOff    <= 1'b0;
    end else begin
      state <= nextState;
      if (wrValid)     sessActive <= 1'b1;
      else if (expire) sessActive <= 1'b0;
      if (expire)               sessPassed <= 1'b0;
      else if (passNow)         sessPassed <= 1'b1;
      if (setPend)       begin pendOn <= 1'b1; pendOff <= 1'b0; end
      else if (clrPend)  begin pendOn <= 1'b0; pendOff <= 1'b1; end
      else if (progDone) begin pendOn <= 1'b0; pendOff <= 1'b0; end
    end
  end

  // lock flag: survives rstN, cleared only by the factory clear
  always_ff @(posedge clk or negedge factoryClrN) begin
    if (!factoryClrN)            protOn <= 1'b0;
    else if (rstN && progDone) begin
      if (pendOn)       protOn <= 1'b1;
      else if (pendOff) protOn <= 1'b0;
    end
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LOAD_LIMIT = 37500,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 17'h05555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 17'h02AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              factoryClrN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              progDone,
  output logic              passValid,
  output logic [ADDR_W-1:0] passAddr,
  output logic [7:0]        passData,
  output logic              dummyKick,
  output logic              protOn
);
  cmdHit_t   hit;
  dpStrobe_t strb;
  logic      gapFull;

  wp_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .factoryClrN(factoryClrN), .wrValid(wrValid),
    .hit(hit), .gapFull(gapFull), .progDone(progDone),
    .strb(strb), .protOn(protOn)
  );

  wp_guard_dp #(
    .ADDR_W(ADDR_W), .LOAD_LIMIT(LOAD_LIMIT),
    .CMD_ADDR_A(CMD_ADDR_A), .CMD_ADDR_B(CMD_ADDR_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .hit(hit), .gapFull(gapFull),
    .passValid(passValid), .passAddr(passAddr), .passData(passData),
    .dummyKick(dummyKick)
  );
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic clk,
  input logic rstN,
  input logic factoryClrN,
  input logic wrValid,
  input logic progDone,
  input logic passValid,
  input logic dummyKick,
  input logic protOn
);
  // R2
  pass_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN || !factoryClrN)
    passValid |-> $past(wrValid));

  // R4
  kick_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN || !factoryClrN)
    dummyKick |-> !$past(wrValid));

  // R11
  kick_pass_excl_chk: assert property (@(posedge clk) disable iff (!rstN || !factoryClrN)
    !(dummyKick && passValid));

  // R3
  lock_after_prog_chk: assert property (@(posedge clk) disable iff (!rstN || !factoryClrN)
    !$stable(protOn) |-> $past(progDone));
endmodule

bind wp_guard wp_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .factoryClrN(factoryClrN), .wrValid(wrValid),
  .progDone(progDone), .passValid(passValid), .dummyKick(dummyKick), .protOn(protOn)
);

// File: tb/wp_guard_tb.sv
`timescale 1ns/1ps
module wp_guard_tb;
  localparam int L = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0, factoryClrN = 1'b0, wrValid = 1'b0, progDone = 1'b0;
  logic [16:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic passValid, dummyKick, protOn;
  logic [16:0] passAddr;
  logic [7:0]  passData;
  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wp_guard #(.ADDR_W(17), .LOAD_LIMIT(L)) u_dut (
    .clk(clk), .rstN(rstN), .factoryClrN(factoryClrN), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .progDone(progDone),
    .passValid(passValid), .passAddr(passAddr), .passData(passData),
    .dummyKick(dummyKick), .protOn(protOn)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [16:0] a, logic [7:0] d, bit expPass, string tag);
    wrAddr = a; wrData = d; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
    chk(passValid == expPass, {tag, " passValid"}, passValid, expPass);
    if (expPass) begin
      chk(passAddr == a, {tag, " passAddr"}, passAddr, a);
      chk(passData == d, {tag, " passData"}, passData, d);
    end
  endtask

  task automatic endSess(bit expKick, string tag);
    idle(L);
    chk(dummyKick == expKick, {tag, " dummyKick"}, dummyKick, expKick);
    idle(1);
  endtask

  task automatic pulseProg();
    progDone = 1'b1;
    @(negedge clk);
    progDone = 1'b0;
  endtask

  function automatic logic [16:0] sAddr(int i);
    return (i % 3 == 1) ? 17'h02AAA : 17'h05555;
  endfunction

  function automatic logic [7:0] sData(int i, bit dis);
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2: return dis ? 8'h80 : 8'hA0;
      default: return 8'h20;
    endcase
  endfunction

  task automatic sendSeq(int n, bit dis, string tag);
    for (int i = 0; i < n; i++) wr(sAddr(i), sData(i, dis), 1'b0, tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
  endtask

  initial begin
    idle(3);
    factoryClrN = 1'b1;
    rstN = 1'b1;
    // R1 reset state
    chk(protOn == 1'b0, "R1 protOn", protOn, 0);
    chk(passValid == 1'b0, "R1 passValid", passValid, 0);
    chk(dummyKick == 1'b0, "R1 dummyKick", dummyKick, 0);

    // R2 sweep of ordinary writes, lock off
    for (int i = 0; i < 32; i++)
      wr(17'((i * 4099 + 7) % 131072), 8'((i * 37 + 5) % 256), 1'b1, "R2 sweep");
    endSess(1'b0, "R11 passed session");

    // R8 unlocked breaks at every partial position
    for (int p = 1; p <= 5; p++) begin
      sendSeq(p, 1'b1, "R8 partial");
      wr(17'h00300 + 17'(p), 8'(p), 1'b1, "R8 break unlocked");
      endSess(1'b0, "R8 unlocked session");
    end
    chk(protOn == 1'b0, "R8 lock unchanged", protOn, 0);

    // R3 enable
    sendSeq(3, 1'b0, "R3 enable");
    endSess(1'b1, "R3 command session");
    chk(protOn == 1'b0, "R3 before progDone", protOn, 0);
    pulseProg();
    chk(protOn == 1'b1, "R3 after progDone", protOn, 1);

    // R9 logic reset keeps the lock
    rstN = 1'b0; idle(2); rstN = 1'b1; idle(1);
    chk(protOn == 1'b1, "R9 after reset", protOn, 1);

    // R4 unprefixed write swallowed, dummy kick
    wr(17'h00100, 8'h3C, 1'b0, "R4 unprefixed");
    endSess(1'b1, "R4 kick");

    // R5 / R10 prefixed data
    sendSeq(3, 1'b0, "R5 prefix");
    wr(17'h00200, 8'h77, 1'b1, "R5 data");
    wr(17'h05555, 8'hAA, 1'b1, "R10 command address data");
    endSess(1'b0, "R11 no kick");
    pulseProg();
    chk(protOn == 1'b1, "R5 lock kept", protOn, 1);

    // R7 gap sweep between prefix and data
    for (int n = 0; n <= L + 1; n++) begin
      sendSeq(3, 1'b0, "R7 prefix");
      idle(n);
      wr(17'h00400 + 17'(n), 8'(n), (n <= L - 1), "R7 gap");
      idle(L + 2);
    end

    // R8 locked breaks at every partial position
    for (int p = 1; p <= 5; p++) begin
      sendSeq(p, 1'b1, "R8 partial locked");
      wr(17'h00300 + 17'(p), 8'(p), 1'b0, "R8 break locked");
      endSess(1'b1, "R8 locked session");
    end
    pulseProg();
    chk(protOn == 1'b1, "R8 lock kept", protOn, 1);

    // R6 disable
    sendSeq(6, 1'b1, "R6 disable");
    endSess(1'b1, "R6 command session");
    chk(protOn == 1'b1, "R6 before progDone", protOn, 1);
    pulseProg();
    chk(protOn == 1'b0, "R6 after progDone", protOn, 0);
    wr(17'h00500, 8'h5A, 1'b1, "R6 ordinary after unlock");
    endSess(1'b0, "R6 session");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule